// File: doc/BRIEF.md
# Sample-Rate-Driven Reference Clock Scaler

This block derives an outgoing reference clock from the internal synthesizer clock. The synthesizer runs at one of two frequencies, chosen by the family of the current sample rate: 24.576 MHz for the 8 kHz family and 22.5792 MHz for the 11.025 kHz family. The scaler divides the synthesizer clock by 1, 2 or 4, and the group that the decoded sample rate belongs to selects the ratio. The outgoing clock therefore stays near a fixed multiple of the audio sample rate.

Two configuration bits change the automatic choice. A bypass bit forces the undivided synthesizer clock out. An extra-halving bit adds one more divide-by-2 stage after the automatic scaler. Configuration words arrive over a valid/ready write port. The port is ready only while the processor enable is set, and no other transfer is possible. Ready is driven combinationally from the processor enable. A word is taken on a rising clock edge where valid and ready are both high. The block holds no buffer, so a word offered while ready is low is not stored, and the source must hold valid until ready is seen. Either enable, processor or codec, lets the outgoing clock run. With both clear the output stays low.

Ratio and enable changes take effect only when the divider counter wraps, so every high and low phase has its full length.

Top module: `refclk_scaler`

## Requirements
- R1: Rate codes 0, 1 and 2 (48, 44.1 and 32 kHz) select an automatic divide-by-1.
- R2: Rate codes 3, 4 and 5 (24, 22.05 and 16 kHz) select an automatic divide-by-2.
- R3: Rate codes 6, 7 and 8 (12, 11.025 and 8 kHz) select an automatic divide-by-4. Codes 9 to 15 fall back to divide-by-1.
- R4: When configuration bit 8 (bypass) is set, the output is the undivided synthesizer clock, whatever bit 17 holds.
- R5: When bit 8 is clear and configuration bit 17 is set, the automatic ratio is doubled, giving overall ratios of 2, 4 or 8.
- R6: For an overall ratio N, the output period is N synthesizer periods and the high time is half of it. This holds at both synthesizer frequencies, 24.576 MHz and 22.5792 MHz.
- R7: The output runs while proc_en or codec_en is set. With both clear it is held low.
- R8: cfg_ready equals proc_en, and a configuration word is stored only on a valid-and-ready edge. Settings written earlier stay in effect after proc_en is cleared.
- R9: A new ratio or a new enable state is applied only at a divider counter wrap, so no output pulse is shorter than one synthesizer half-period times the smaller ratio.
- R10: Reset clears both configuration bits, sets divide-by-1 and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| synth_clk | input | 1 | Synthesizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 4 | Decoded sample-rate code |
| proc_en | input | 1 | Processor enable; also opens the configuration port |
| codec_en | input | 1 | Codec enable |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration port ready (follows proc_en) |
| cfg_data | input | 18 | Configuration word; bit 8 bypass, bit 17 extra halving |
| ref_clk_o | output | 1 | Scaled reference clock output |

## Verification
Every cycle, the assertions check that the ratio changes only on a counter wrap, that the counter stays inside the current span, that the divided output is low while the gate is closed, and that the configuration bits hold still while the processor is disabled. Only the bench scenarios can show the real-time properties: the output period and high time for each rate group and configuration at both synthesizer frequencies, the absence of short pulses across a ratio change, and settings that outlive the processor enable.

// File: rtl/refclk_scaler_pkg.sv
package refclk_scaler_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CODE_W    = 4;
  localparam int MAX_SHIFT = 3;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  typedef logic [SHIFT_W-1:0] shift_t;

  typedef enum logic [CODE_W-1:0] {
    SR_48K    = 4'd0,
    SR_44K1   = 4'd1,
    SR_32K    = 4'd2,
    SR_24K    = 4'd3,
    SR_22K05  = 4'd4,
    SR_16K    = 4'd5,
    SR_12K    = 4'd6,
    SR_11K025 = 4'd7,
    SR_8K     = 4'd8
  } rate_e;
endpackage

// File: rtl/rate_decode.sv
module rate_decode
  import refclk_scaler_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output shift_t            auto_shift_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // rate group to log2 of the automatic ratio (R1, R2, R3)
  always_comb begin
    case (code_i)
      SR_48K, SR_44K1, SR_32K:    auto_shift_o = shift_t'(0);
      SR_24K, SR_22K05, SR_16K:   auto_shift_o = shift_t'(1);
      SR_12K, SR_11K025, SR_8K:   auto_shift_o = shift_t'(2);
      default:                    auto_shift_o = shift_t'(0);
    endcase
  end

  // R3: the automatic scaler never exceeds divide-by-4
  always_comb begin
    a_r3_auto_in_range: assert (auto_shift_o <= shift_t'(2))
      else $error("automatic shift out of range");
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int CFG_W    = 18,
  parameter int BYP_BIT  = 8,
  parameter int HALF_BIT = 17
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             proc_en_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic             bypass_o,
  output logic             xhalf_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic take;

  assign wr_ready_o = proc_en_i;
  assign take       = wr_valid_i && wr_ready_o;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      bypass_o <= 1'b0;
      xhalf_o  <= 1'b0;
    end else if (take) begin
      bypass_o <= wr_data_i[BYP_BIT];
      xhalf_o  <= wr_data_i[HALF_BIT];
    end
  end

  // R8: settings frozen while the processor is disabled
  a_r8_frozen_without_proc: assert property (@(posedge clk_i) disable iff (!rst_n)
    !proc_en_i |=> ($stable(bypass_o) && $stable(xhalf_o)))
    else $error("configuration changed while processor disabled");
endmodule

// File: rtl/shift_select.sv
module shift_select
  import refclk_scaler_pkg::*;
(
  input  shift_t auto_shift_i,
  input  logic   bypass_i,
  input  logic   xhalf_i,
  output shift_t shift_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // R4 bypass wins; R5 extra halving stacks on the automatic ratio
  always_comb begin
    if (bypass_i)     shift_o = shift_t'(0);
    else if (xhalf_i) shift_o = auto_shift_i + shift_t'(1);
    else              shift_o = auto_shift_i;
  end
endmodule

// File: rtl/div_core.sv
module div_core
  import refclk_scaler_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_n,
  input  logic   run_req_i,
  input  shift_t shift_req_i,
  output logic   clk_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  shift_t           k_q, k_nxt;
  logic             run_q, run_nxt;
  logic             div_q, div_nxt;
  logic             gate_n_q;
  logic             wrap;
  int unsigned      span, half_nxt;

  always_comb begin
    span     = 32'd1 << k_q;
    wrap     = (int'(cnt_q) == int'(span) - 1);
    k_nxt    = wrap ? shift_req_i : k_q;
    run_nxt  = wrap ? run_req_i   : run_q;
    cnt_nxt  = wrap ? '0 : cnt_q + 1'b1;
    half_nxt = (32'd1 << k_nxt) >> 1;
    div_nxt  = run_nxt && (int'(cnt_nxt) < int'(half_nxt));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      k_q   <= '0;
      run_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      k_q   <= k_nxt;
      run_q <= run_nxt;
      div_q <= div_nxt;
    end
  end

  // divide-by-1 gate opened or closed only while the clock is low
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) gate_n_q <= 1'b0;
    else        gate_n_q <= run_q;
  end

  assign clk_o = (k_q == shift_t'(0)) ? (clk_i & gate_n_q) : div_q;

  // R9: the ratio moves only on a wrap
  a_r9_shift_changes_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (k_q != $past(k_q)) |-> $past(wrap))
    else $error("ratio changed away from a wrap");

  // R6: counter never leaves the current span
  a_r6_count_in_span: assert property (@(posedge clk_i) disable iff (!rst_n)
    int'(cnt_q) < (1 << int'(k_q)))
    else $error("divider count outside span");

  // R7: divided output low while gate closed
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_q |-> !div_q)
    else $error("divided output high while gated");
endmodule

// File: rtl/refclk_scaler.sv
module refclk_scaler
  import refclk_scaler_pkg::*;
#(
  parameter int CFG_W    = 18,
  parameter int BYP_BIT  = 8,
  parameter int HALF_BIT = 17
) (
  input  logic             synth_clk,
  input  logic             rst_n,
  input  logic [3:0]       rate_code,
  input  logic             proc_en,
  input  logic             codec_en,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             ref_clk_o
);
  timeunit 1ns;
  timeprecision 1ps;

  shift_t auto_shift, sel_shift;
  logic   bypass, xhalf;

  rate_decode u_dec (
    .code_i       (rate_code),
    .auto_shift_o (auto_shift)
  );

  cfg_store #(.CFG_W(CFG_W), .BYP_BIT(BYP_BIT), .HALF_BIT(HALF_BIT)) u_cfg (
    .clk_i      (synth_clk),
    .rst_n      (rst_n),
    .proc_en_i  (proc_en),
    .wr_valid_i (cfg_valid),
    .wr_ready_o (cfg_ready),
    .wr_data_i  (cfg_data),
    .bypass_o   (bypass),
    .xhalf_o    (xhalf)
  );

  shift_select u_sel (
    .auto_shift_i (auto_shift),
    .bypass_i     (bypass),
    .xhalf_i      (xhalf),
    .shift_o      (sel_shift)
  );

  div_core u_div (
    .clk_i       (synth_clk),
    .rst_n       (rst_n),
    .run_req_i   (proc_en | codec_en),
    .shift_req_i (sel_shift),
    .clk_o       (ref_clk_o)
  );
endmodule

// File: tb/refclk_scaler_test.sv
module refclk_scaler_test;
  timeunit 1ns;
  timeprecision 1ps;

  real  half_ns = 10.0;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic proc_en = 1'b0, codec_en = 1'b0, cfg_valid = 1'b0;
  logic [17:0] cfg_data = '0;
  logic cfg_ready, ref_clk_o;

  int checks = 0, fails = 0, cyc = 0, edges = 0;
  bit done = 0;

  always #(half_ns) clk = ~clk;

  refclk_scaler uut (
    .synth_clk(clk), .rst_n(rst_n), .rate_code(rate_code),
    .proc_en(proc_en), .codec_en(codec_en), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_data(cfg_data), .ref_clk_o(ref_clk_o)
  );

  always @(posedge ref_clk_o) edges++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // {code[10:7], bypass[6], xhalf[5], family44k1[4], ratio[3:0]}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 1'b0, 4'd1},   // R1 48k
    {4'd1, 1'b0, 1'b0, 1'b1, 4'd1},   // R1 44.1k
    {4'd3, 1'b0, 1'b0, 1'b0, 4'd2},   // R2 24k
    {4'd4, 1'b0, 1'b0, 1'b1, 4'd2},   // R2 22.05k
    {4'd6, 1'b0, 1'b0, 1'b0, 4'd4},   // R3 12k
    {4'd7, 1'b0, 1'b0, 1'b1, 4'd4},   // R3 11.025k
    {4'd8, 1'b0, 1'b0, 1'b0, 4'd4},   // R3 8k
    {4'd12, 1'b0, 1'b0, 1'b0, 4'd1},  // R3 unused code
    {4'd2, 1'b0, 1'b1, 1'b0, 4'd2},   // R5 32k halved
    {4'd5, 1'b0, 1'b1, 1'b0, 4'd4},   // R5 16k halved
    {4'd8, 1'b0, 1'b1, 1'b0, 4'd8},   // R5 8k halved
    {4'd7, 1'b0, 1'b1, 1'b1, 4'd8},   // R5 11.025k halved
    {4'd6, 1'b1, 1'b0, 1'b0, 4'd1},   // R4 bypass
    {4'd6, 1'b1, 1'b1, 1'b1, 4'd1}    // R4 bypass beats halving
  };

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_real(input string tag, input real act, input real exp);
    checks++;
    if (act - exp > 0.02 || exp - act > 0.02) begin
      fails++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic byp, input logic xh);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data = '0;
    cfg_data[8] = byp;
    cfg_data[17] = xh;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge ref_clk_o); t0 = $realtime;
    @(negedge ref_clk_o); t1 = $realtime;
    @(posedge ref_clk_o); t2 = $realtime;
    per = t2 - t0;
    hi = t1 - t0;
  endtask

  task automatic count_edges(input int n, output int cnt);
    int e0;
    e0 = edges;
    repeat (n) @(negedge clk);
    cnt = edges - e0;
  endtask

  initial begin
    real per, hi, minhi;
    int cnt;

    // R10 reset state
    proc_en = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R10 output low in reset", ref_clk_o, 1'b0);
    #(half_ns * 0.5);
    chk_bit("R10 output low in reset mid-phase", ref_clk_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    measure(per, hi);
    chk_real("R10 divide-by-1 after reset", per, 20.0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      half_ns = VEC[i][4] ? 22.144 : 20.345;
      write_cfg(VEC[i][6], VEC[i][5]);
      rate_code = VEC[i][10:7];
      repeat (24) @(negedge clk);
      measure(per, hi);
      chk_real($sformatf("R6 period vec %0d", i), per, 2.0 * half_ns * real'(VEC[i][3:0]));
      chk_real($sformatf("R6 high time vec %0d", i), hi, half_ns * real'(VEC[i][3:0]));
    end

    half_ns = 10.0;
    write_cfg(1'b0, 1'b0);

    // R7 gating
    rate_code = 4'd6;
    proc_en = 1'b0; codec_en = 1'b1;
    repeat (12) @(negedge clk);
    measure(per, hi);
    chk_real("R7 runs on codec enable", per, 80.0);
    codec_en = 1'b0;
    repeat (12) @(negedge clk);
    count_edges(40, cnt);
    chk_bit("R7 no edges when disabled", cnt == 0, 1'b1);
    chk_bit("R7 output low when disabled", ref_clk_o, 1'b0);
    rate_code = 4'd0;
    repeat (12) @(negedge clk);
    count_edges(20, cnt);
    chk_bit("R7 no edges when disabled at div1", cnt == 0, 1'b1);

    // R8 write port and retention
    proc_en = 1'b1;
    rate_code = 4'd6;
    write_cfg(1'b1, 1'b0);
    proc_en = 1'b0; codec_en = 1'b1;
    chk_bit("R8 ready follows proc_en", cfg_ready, 1'b0);
    write_cfg(1'b0, 1'b1);
    repeat (12) @(negedge clk);
    measure(per, hi);
    chk_real("R8 settings retained, blocked write ignored", per, 20.0);
    proc_en = 1'b1;
    chk_bit("R8 ready high with proc_en", cfg_ready, 1'b1);
    write_cfg(1'b0, 1'b0);
    repeat (12) @(negedge clk);
    measure(per, hi);
    chk_real("R8 write accepted with proc_en", per, 80.0);

    // R9 no short pulses across ratio changes
    minhi = 1.0e9;
    rate_code = 4'd0;
    for (int p = 0; p < 10; p++) begin
      measure(per, hi);
      if (hi < minhi) minhi = hi;
      if (per - hi < minhi) minhi = per - hi;
    end
    write_cfg(1'b0, 1'b1);
    rate_code = 4'd8;
    for (int p = 0; p < 6; p++) begin
      measure(per, hi);
      if (hi < minhi) minhi = hi;
      if (per - hi < minhi) minhi = per - hi;
    end
    chk_bit("R9 no phase shorter than a half period", minhi > 9.98, 1'b1);
    chk_real("R9 final ratio after switch", per, 160.0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule